// File: doc/BRIEF.md
# Three-Threshold Hit Latch and Encoder

This block is the digital hit logic that sits behind the analog front end of a multi-channel charge readout chip. Each channel has three comparator outputs at rising charge thresholds: low, middle and high. The block takes them as synchronous digital levels. Each level has its own configuration mask bit and its own sticky latch. A latch sets on a rising edge of its comparator input. The three latch states of a channel are folded into a 2-bit hit code. For each threshold level, one trigger line carries the OR of that level's unmasked latches across all channels.

The latches are emptied by a channel-clear strobe, or automatically when the trigger has stood for a programmable number of cycles without an event-valid strobe. An event-valid strobe that arrives while a trigger is standing accepts the event. The accepted hit codes then stay frozen until the channel-clear strobe. A downstream memory stage reads the hit codes; that stage is not part of this block.

Top module: `trihit_top`

## Requirements
- R1: Channel c drives `hitCode[2c+1:2c]`. Comparator level l of channel c is input bit `discIn[3c+l]`, where l=0 is low, 1 is middle and 2 is high. The code is 00 for no latched level, 01 for low only, 10 for low and middle, and 11 for all three.
- R2: A latched pattern that is not nested (for example middle only, or high without low) is encoded by its highest latched level: high gives 11, middle without high gives 10.
- R3: A latch sets one clock edge after its comparator input is first sampled high following a sampled low. It then holds until it is cleared. An input that stays high across a clear does not set the latch again.
- R4: When mask bit `maskCfg[3c+l]` is 1, level l of channel c cannot set its latch and does not contribute to trigger l.
- R5: `trigOut[l]` is the OR, over all channels, of latched and unmasked level l.
- R6: A channel-clear strobe (`chanClr` high at a clock edge) empties every latch at that edge. It takes priority over a rising comparator input in the same cycle.
- R7: With `winLen` = N > 0 and no event-valid strobe, a trigger stays visible for exactly N cycles. All latches are then empty from the following cycle on.
- R8: `evtValid` high while any trigger is visible cancels the automatic clear, and the latches hold until `chanClr`. This also applies when `evtValid` falls in the last cycle of the window.
- R9: `winLen` = 0 disables the automatic clear.
- R10: After reset, all codes and triggers are zero. A comparator input that is already high when reset is released is not treated as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| discIn | input | NUM_CH*3 | Comparator levels, bit 3c+l is level l of channel c |
| maskCfg | input | NUM_CH*3 | Mask bits, 1 blocks that level |
| chanClr | input | 1 | Channel-clear strobe |
| evtValid | input | 1 | Event-valid strobe |
| winLen | input | WIN_W | Automatic clear window in cycles, 0 disables it |
| hitCode | output | NUM_CH*2 | Per-channel 2-bit hit code |
| trigOut | output | 3 | Per-level trigger OR across channels |

## Verification
The assertions take for granted that the comparator levels, masks and window length are synchronous to the clock. They also assume that masks and window length are changed only while the latches are empty, so that a trigger cannot vanish from a mask change alone. The bench drives every input on the falling edge. It changes masks and the window only right after a channel clear. An exhaustive sweep over every pattern and mask on each channel of a four-channel build covers the encoding, then targeted sequences cover the window boundaries and strobe collisions.

// File: rtl/trihit_pkg.sv
`timescale 1ns/1ps
package trihit_pkg;
  localparam int LVL = 3;
  localparam int CODE_W = 2;

  typedef struct packed {
    logic chanClr;
    logic autoClr;
  } clrStb_t;

  function automatic logic [CODE_W-1:0] encodeLvl(input logic [LVL-1:0] lat);
    if (lat[2])      return 2'b11;
    else if (lat[1]) return 2'b10;
    else if (lat[0]) return 2'b01;
    else             return 2'b00;
  endfunction
endpackage

// File: rtl/trihit_chan.sv
`timescale 1ns/1ps
module trihit_chan
  import trihit_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LVL-1:0]    disc,
  input  logic [LVL-1:0]    mask,
  input  logic              clr,
  output logic [LVL-1:0]    lat,
  output logic [CODE_W-1:0] code
);
  logic [LVL-1:0] prevDisc;
  logic [LVL-1:0] riseHit;

  assign riseHit = disc & ~prevDisc & ~mask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevDisc <= '1;
      lat      <= '0;
    end else begin
      prevDisc <= disc;
      if (clr) lat <= '0;
      else     lat <= lat | riseHit;
    end
  end

  assign code = encodeLvl(lat);
endmodule

// File: rtl/trihit_dp.sv
`timescale 1ns/1ps
module trihit_dp
  import trihit_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*LVL-1:0]    discIn,
  input  logic [NUM_CH*LVL-1:0]    maskCfg,
  input  clrStb_t                  stb,
  output logic [NUM_CH*LVL-1:0]    latVec,
  output logic [NUM_CH*CODE_W-1:0] hitCode,
  output logic [LVL-1:0]           trigOut
);
  logic clrAll;
  assign clrAll = stb.chanClr | stb.autoClr;

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    trihit_chan uChan (
      .clk  (clk),
      .rstN (rstN),
      .disc (discIn[c*LVL +: LVL]),
      .mask (maskCfg[c*LVL +: LVL]),
      .clr  (clrAll),
      .lat  (latVec[c*LVL +: LVL]),
      .code (hitCode[c*CODE_W +: CODE_W])
    );
  end

  for (genvar l = 0; l < LVL; l++) begin : gTrig
    logic [NUM_CH-1:0] levelHits;
    for (genvar c = 0; c < NUM_CH; c++) begin : gTap
      assign levelHits[c] = latVec[c*LVL+l] & ~maskCfg[c*LVL+l];
    end
    assign trigOut[l] = |levelHits;
  end
endmodule

// File: rtl/trihit_ctrl.sv
`timescale 1ns/1ps
module trihit_ctrl
  import trihit_pkg::*;
#(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanClr,
  input  logic             evtValid,
  input  logic             anyHit,
  input  logic [WIN_W-1:0] winLen,
  output clrStb_t          stb
);
  logic             accepted;
  logic [WIN_W-1:0] winCnt;
  logic             lastCycle;
  logic             expire;

  assign lastCycle = (({1'b0, winCnt} + (WIN_W+1)'(1)) == {1'b0, winLen});
  assign expire    = anyHit && !accepted && !evtValid && !chanClr && lastCycle;

  always_comb begin
    stb.chanClr = chanClr;
    stb.autoClr = expire;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accepted <= 1'b0;
      winCnt   <= '0;
    end else if (chanClr || expire || !anyHit) begin
      accepted <= 1'b0;
      winCnt   <= '0;
    end else if (evtValid || accepted) begin
      accepted <= 1'b1;
      winCnt   <= '0;
    end else begin
      winCnt   <= winCnt + 1'b1;
    end
  end
endmodule

// File: rtl/trihit_top.sv
`timescale 1ns/1ps
module trihit_top
  import trihit_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int WIN_W  = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [NUM_CH*3-1:0]      discIn,
  input  logic [NUM_CH*3-1:0]      maskCfg,
  input  logic                     chanClr,
  input  logic                     evtValid,
  input  logic [WIN_W-1:0]         winLen,
  output logic [NUM_CH*2-1:0]      hitCode,
  output logic [2:0]               trigOut
);
  clrStb_t                ctrlStb;
  logic [NUM_CH*LVL-1:0]  latVec;

  trihit_ctrl #(.WIN_W(WIN_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .chanClr  (chanClr),
    .evtValid (evtValid),
    .anyHit   (|trigOut),
    .winLen   (winLen),
    .stb      (ctrlStb)
  );

  trihit_dp #(.NUM_CH(NUM_CH)) uDp (
    .clk     (clk),
    .rstN    (rstN),
    .discIn  (discIn),
    .maskCfg (maskCfg),
    .stb     (ctrlStb),
    .latVec  (latVec),
    .hitCode (hitCode),
    .trigOut (trigOut)
  );
endmodule

// File: rtl/trihit_chk.sv
`timescale 1ns/1ps
module trihit_chk
  import trihit_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int WIN_W  = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  chanClr,
  input logic                  evtValid,
  input logic [WIN_W-1:0]      winLen,
  input logic [NUM_CH*2-1:0]   hitCode,
  input logic [2:0]            trigOut,
  input logic [NUM_CH*3-1:0]   latVec,
  input clrStb_t               ctrlStb
);
  // R6
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    chanClr |=> (hitCode == '0 && trigOut == '0));

  // R7
  auto_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStb.autoClr |=> (hitCode == '0 && trigOut == '0));

  // R8
  accept_blocks_auto_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> !ctrlStb.autoClr);

  // R9
  zero_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winLen == '0) |-> !ctrlStb.autoClr);

  // R3
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlStb.chanClr || ctrlStb.autoClr) |=> ((latVec & $past(latVec)) == $past(latVec)));

  // R5
  trig_needs_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hitCode == '0) |-> (trigOut == '0));
endmodule

bind trihit_top trihit_chk #(.NUM_CH(NUM_CH), .WIN_W(WIN_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .chanClr  (chanClr),
  .evtValid (evtValid),
  .winLen   (winLen),
  .hitCode  (hitCode),
  .trigOut  (trigOut),
  .latVec   (latVec),
  .ctrlStb  (ctrlStb)
);

// File: tb/sim_trihit_top.sv
`timescale 1ns/1ps
module sim_trihit_top;
  localparam int NCH = 4;
  localparam int WW  = 4;

  logic              clk = 1'b0;
  logic              rstN;
  logic [NCH*3-1:0]  discIn;
  logic [NCH*3-1:0]  maskCfg;
  logic              chanClr;
  logic              evtValid;
  logic [WW-1:0]     winLen;
  logic [NCH*2-1:0]  hitCode;
  logic [2:0]        trigOut;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  always #4 clk = ~clk;

  trihit_top #(.NUM_CH(NCH), .WIN_W(WW)) u0 (
    .clk(clk), .rstN(rstN), .discIn(discIn), .maskCfg(maskCfg),
    .chanClr(chanClr), .evtValid(evtValid), .winLen(winLen),
    .hitCode(hitCode), .trigOut(trigOut)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  function automatic logic [1:0] expCode(input logic [2:0] p);
    if (p[2]) return 2'd3;
    if (p[1]) return 2'd2;
    if (p[0]) return 2'd1;
    return 2'd0;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic clearAll();
    chanClr = 1'b1; tick(); chanClr = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; discIn = '1; maskCfg = '0; chanClr = 1'b0; evtValid = 1'b0; winLen = '0;
    @(negedge clk); tick(); tick();
    rstN = 1'b1;
    tick(); tick();
    // R10: input high at reset release is no rising edge
    chk(hitCode == '0 && trigOut == '0, "R10 reset", {hitCode, 1'b0, trigOut}, 0);
    discIn = '0; tick();

    // R1 R2 R4 exhaustive sweep per channel
    for (int ch = 0; ch < NCH; ch++) begin
      for (int p = 0; p < 8; p++) begin
        for (int m = 0; m < 8; m++) begin
          logic [2:0] eff;
          logic [NCH*2-1:0] expV;
          string tag;
          maskCfg = '0; maskCfg[ch*3 +: 3] = 3'(m);
          discIn = '0; clearAll();
          discIn[ch*3 +: 3] = 3'(p); tick();
          eff = 3'(p) & ~3'(m);
          expV = '0; expV[ch*2 +: 2] = expCode(eff);
          if (m != 0) tag = "R4 mask";
          else if (eff == 3'd0 || eff == 3'd1 || eff == 3'd3 || eff == 3'd7) tag = "R1 code";
          else tag = "R2 highest";
          chk(hitCode == expV, tag, hitCode, expV);
          chk(trigOut == eff, "R4 R5 trig", trigOut, eff);
        end
      end
    end

    // R5: multi-channel trigger OR
    for (int v = 0; v < 16; v++) begin
      logic [2:0] expT;
      logic [NCH*2-1:0] expV;
      discIn = '0; maskCfg = '0; clearAll();
      expT = '0; expV = '0;
      for (int c = 0; c < NCH; c++) begin
        logic [2:0] pp, mm;
        pp = 3'((v*5 + c*3) % 8);
        mm = 3'((v + c*2) % 8);
        maskCfg[c*3 +: 3] = mm;
        discIn[c*3 +: 3] = pp;
        expT |= pp & ~mm;
        expV[c*2 +: 2] = expCode(pp & ~mm);
      end
      tick();
      chk(trigOut == expT, "R5 or", trigOut, expT);
      chk(hitCode == expV, "R5 codes", hitCode, expV);
    end

    // R3: set on edge, hold, no re-set from a held level
    maskCfg = '0; discIn = '0; clearAll();
    discIn[0] = 1'b1; tick();
    discIn[0] = 1'b0; tick(); tick();
    chk(hitCode == 8'h01, "R3 hold", hitCode, 8'h01);
    discIn[0] = 1'b1; tick();
    clearAll(); tick(); tick();
    chk(hitCode == '0, "R3 held level", hitCode, 0);
    discIn[0] = 1'b0; tick(); discIn[0] = 1'b1; tick();
    chk(hitCode == 8'h01, "R3 new edge", hitCode, 8'h01);

    // R6: clear beats a simultaneous rising edge
    discIn = '0; clearAll();
    discIn[5:3] = 3'b111; chanClr = 1'b1; tick(); chanClr = 1'b0;
    chk(hitCode == '0 && trigOut == '0, "R6 priority", hitCode, 0);

    // R7: window of 5 cycles
    discIn = '0; clearAll(); winLen = 4'd5;
    discIn[0] = 1'b1; tick(); discIn[0] = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      chk(trigOut == 3'b001, "R7 visible", trigOut, 1);
      tick();
    end
    chk(trigOut == '0 && hitCode == '0, "R7 expired", trigOut, 0);

    // R8: accept mid-window
    clearAll(); winLen = 4'd3;
    discIn[3] = 1'b1; tick(); discIn[3] = 1'b0;
    evtValid = 1'b1; tick(); evtValid = 1'b0;
    for (int k = 0; k < 10; k++) tick();
    chk(hitCode == 8'h04, "R8 accepted", hitCode, 8'h04);
    clearAll();
    chk(hitCode == '0, "R8 released by clear", hitCode, 0);

    // R8: accept in the last window cycle
    discIn[6] = 1'b1; tick(); discIn[6] = 1'b0;
    tick(); tick();
    evtValid = 1'b1; tick(); evtValid = 1'b0;
    for (int k = 0; k < 6; k++) tick();
    chk(trigOut == 3'b001 && hitCode == 8'h10, "R8 last cycle", hitCode, 8'h10);

    // R9: window disabled
    clearAll(); winLen = '0;
    discIn[11:9] = 3'b111; tick();
    for (int k = 0; k < 40; k++) tick();
    chk(hitCode == 8'hC0 && trigOut == 3'b111, "R9 no auto", hitCode, 8'hC0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule